// File: doc/BRIEF.md
# Illegal Opcode Exception Trap Unit

This block inspects each 32-bit instruction word that is about to be executed and raises an exception trap when the word falls into the reserved illegal encoding. The encoding is split across two fields. The six bits [10:5] must all be ones. The four bits [26:23] must hold any value from 3 to 15. Every other bit of the word is ignored.

On a trap, the whole processor-state update is done in one clock edge. The restored program counter is copied into a saved-PC register, and the current status word into a saved-status register. A fixed cause code goes into the low half of the cause register, while the high half is carried over from the current cause value. The status word leaves with its two trap flags set, and the program counter is forced to a fixed handler address. On all other cycles, the status, cause and program-counter outputs follow the values the core supplies, and both saved registers hold their contents.

Top module: `badop_trap`

## Requirements
- R1: When `insn_vld` is high and `insn` has bits [10:5] equal to 6'b111111 and bits [26:23] in the range 4'd3 to 4'd15, `trap` is high for exactly the one cycle that follows that clock edge.
- R2: A word whose bits [26:23] equal 0, 1 or 2 never traps, even when bits [10:5] are all ones.
- R3: A word with at least one zero in bits [10:5] never traps. No word traps while `insn_vld` is low.
- R4: On a trap, `epc` takes the value of `ret_pc`. On other cycles, `epc` keeps its value.
- R5: On a trap, `epsw` takes the value of `cur_psw` as it was before the flags are set. On other cycles, `epsw` keeps its value.
- R6: On a trap, `cause[15:0]` becomes 16'h0060 and `cause[31:16]` takes `cur_cause[31:16]`. On other cycles, `cause` takes `cur_cause`.
- R7: On a trap, `psw` equals `cur_psw` with bit 6 (exception-pending flag) and bit 5 (interrupt-disable flag) set to 1. On other cycles, `psw` equals `cur_psw`.
- R8: On a trap, `pc` becomes 32'h0000_0060. On other cycles, `pc` takes `next_pc`.
- R9: A synchronous active-high `rst` clears `epc`, `epsw`, `cause`, `psw`, `pc` and `trap` to zero.
- R10: Bits [31:27], [22:11] and [4:0] of `insn` have no effect on whether a trap is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| insn | input | 32 | Instruction word to be executed next |
| insn_vld | input | 1 | Instruction word is valid this cycle |
| ret_pc | input | 32 | Restored program counter to save on a trap |
| next_pc | input | 32 | Program counter the core would load without a trap |
| cur_psw | input | 32 | Current status word |
| cur_cause | input | 32 | Current cause register value |
| epc | output | 32 | Saved program counter |
| epsw | output | 32 | Saved status word |
| cause | output | 32 | Cause register |
| psw | output | 32 | Updated status word |
| pc | output | 32 | Updated program counter |
| trap | output | 1 | Trap taken, one-cycle pulse |

## Verification
Every result of this block is registered once. The trap pulse and all five register outputs therefore reflect the inputs applied before one rising edge and are valid until the next edge. The bench drives a stimulus on a falling edge, lets one rising edge pass, and reads every output on the following falling edge. It never samples sooner or later than that. The bench also keeps a running model of the two saved registers, so that their hold behaviour on non-trap cycles is checked in the same sampling slot as the trap updates.

// File: rtl/badop_trap.sv
module badop_trap #(
  parameter int          EP_BIT     = 6,
  parameter int          ID_BIT     = 5,
  parameter logic [31:0] VEC_ADDR   = 32'h0000_0060,
  parameter logic [15:0] CAUSE_CODE = 16'h0060
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] insn,
  input  logic        insn_vld,
  input  logic [31:0] ret_pc,
  input  logic [31:0] next_pc,
  input  logic [31:0] cur_psw,
  input  logic [31:0] cur_cause,
  output logic [31:0] epc,
  output logic [31:0] epsw,
  output logic [31:0] cause,
  output logic [31:0] psw,
  output logic [31:0] pc,
  output logic        trap
);
  localparam logic [31:0] FLAG_MASK = (32'd1 << EP_BIT) | (32'd1 << ID_BIT);

  logic ones_field, range_hit, take;

  assign ones_field = &insn[10:5];
  assign range_hit  = insn[26:23] >= 4'd3;
  assign take       = insn_vld && ones_field && range_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      epc   <= '0;
      epsw  <= '0;
      cause <= '0;
      psw   <= '0;
      pc    <= '0;
      trap  <= 1'b0;
    end else begin
      trap <= take;
      if (take) begin
        epc   <= ret_pc;
        epsw  <= cur_psw;
        cause <= {cur_cause[31:16], CAUSE_CODE};
        psw   <= cur_psw | FLAG_MASK;
        pc    <= VEC_ADDR;
      end else begin
        cause <= cur_cause;
        psw   <= cur_psw;
        pc    <= next_pc;
      end
    end
  end

  assert_trap_vector_R8: assert property (@(posedge clk) disable iff (rst)
    trap |-> pc == VEC_ADDR);
  assert_cause_code_R6: assert property (@(posedge clk) disable iff (rst)
    trap |-> cause[15:0] == CAUSE_CODE && cause[31:16] == $past(cur_cause[31:16]));
  assert_flags_set_R7: assert property (@(posedge clk) disable iff (rst)
    trap |-> psw[EP_BIT] && psw[ID_BIT]);
  assert_save_pc_R4: assert property (@(posedge clk) disable iff (rst)
    trap |-> epc == $past(ret_pc));
  assert_save_psw_R5: assert property (@(posedge clk) disable iff (rst)
    trap |-> epsw == $past(cur_psw));
  assert_hold_saved_R4: assert property (@(posedge clk) disable iff (rst)
    !trap |-> $stable(epc) && $stable(epsw));
  assert_no_trap_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !insn_vld |=> !trap);
  assert_low_range_R2: assert property (@(posedge clk) disable iff (rst)
    insn[26:23] < 4'd3 |=> !trap);
endmodule

// File: tb/badop_trap_tb.sv
module badop_trap_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] insn, ret_pc, next_pc, cur_psw, cur_cause;
  logic        insn_vld;
  logic [31:0] epc, epsw, cause, psw, pc;
  logic        trap;

  int n_run = 0, n_fail = 0;
  logic [31:0] m_epc, m_epsw;

  always #4 clk = ~clk;

  badop_trap u_dut (
    .clk(clk), .rst(rst), .insn(insn), .insn_vld(insn_vld),
    .ret_pc(ret_pc), .next_pc(next_pc), .cur_psw(cur_psw), .cur_cause(cur_cause),
    .epc(epc), .epsw(epsw), .cause(cause), .psw(psw), .pc(pc), .trap(trap)
  );

  // {expected trap, word}
  localparam int NV = 10;
  localparam logic [32:0] VEC [NV] = '{
    {1'b1, 32'h0180_07E0},
    {1'b0, 32'h0100_07E0},
    {1'b0, 32'h0000_07E0},
    {1'b1, 32'h0780_07E0},
    {1'b1, 32'hF81F_F81F | 32'h0000_07E0 | 32'h0200_0000},
    {1'b0, 32'hF87F_FFDF},
    {1'b0, 32'h0780_07C0},
    {1'b1, 32'hFFFF_FFFF},
    {1'b0, 32'hF87F_FFFF},
    {1'b0, 32'h0380_03E0}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit is_bad(input logic [31:0] w);
    return (w[10:5] == 6'h3F) && (w[26:23] > 4'd2);
  endfunction

  task automatic step(input logic [31:0] w, input logic v, input string tag);
    logic [31:0] rp, np, ps, ca;
    bit t;
    rp = $urandom; np = $urandom; ps = $urandom & 32'hFFFF_FF9F; ca = $urandom;
    @(negedge clk);
    insn = w; insn_vld = v; ret_pc = rp; next_pc = np; cur_psw = ps; cur_cause = ca;
    t = v && is_bad(w);
    @(posedge clk);
    @(negedge clk);
    chk(trap == t, {tag, " trap"}, {31'd0, trap}, {31'd0, t});
    if (t) begin
      m_epc = rp; m_epsw = ps;
      chk(pc == 32'h60, "R8 pc vector", pc, 32'h60);
      chk(cause == {ca[31:16], 16'h0060}, "R6 cause", cause, {ca[31:16], 16'h0060});
      chk(psw == (ps | 32'h60), "R7 psw flags", psw, ps | 32'h60);
    end else begin
      chk(pc == np, "R8 pc pass", pc, np);
      chk(cause == ca, "R6 cause pass", cause, ca);
      chk(psw == ps, "R7 psw pass", psw, ps);
    end
    chk(epc == m_epc, "R4 epc", epc, m_epc);
    chk(epsw == m_epsw, "R5 epsw", epsw, m_epsw);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; insn = 32'hFFFF_FFFF; insn_vld = 1'b1;
    ret_pc = 32'h1234; next_pc = 32'h5678; cur_psw = 32'h9; cur_cause = 32'hABCD_0000;
    m_epc = '0; m_epsw = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(trap == 1'b0, "R9 reset trap", {31'd0, trap}, 32'd0);
    chk(pc == 0 && psw == 0, "R9 reset pc/psw", pc | psw, 32'd0);
    chk(epc == 0 && epsw == 0 && cause == 0, "R9 reset saved", epc | epsw | cause, 32'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      chk(is_bad(VEC[i][31:0]) == VEC[i][32], "R1 table model", {31'd0, is_bad(VEC[i][31:0])}, {31'd0, VEC[i][32]});
      step(VEC[i][31:0], 1'b1, "R1 R10 table");
    end

    for (int k = 0; k < 16; k++)
      step({5'h15, k[3:0], 12'hA5A, 6'h3F, 5'h0A}, 1'b1, k < 3 ? "R2 low range" : "R1 sweep");

    for (int b = 5; b <= 10; b++)
      step(32'h0780_07E0 & ~(32'd1 << b), 1'b1, "R3 single zero");

    step(32'h0780_07E0, 1'b0, "R3 not valid");
    step(32'h0780_07E0, 1'b1, "R1 back to back a");
    step(32'h0180_07E0, 1'b1, "R1 back to back b");
    step(32'h0100_07E0, 1'b1, "R2 after trap");
    step(32'h0000_07E0 | 32'hF87F_F81F, 1'b1, "R10 dont care set");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule